// File: doc/BRIEF.md
# Dual-Halfword Signed Long Multiply-Accumulator

This block is one pipeline stage of an execution datapath. It takes two 32-bit operands, A and B, and a 64-bit running sum that arrives as a low word and a high word. It returns the updated 64-bit sum, again split into low and high words. A two-bit opcode picks one of four multiply forms. Two select bits choose halfwords for the single-halfword form.

- The full form multiplies A and B as signed 32-bit values.
- The single form multiplies one signed halfword of A with one signed halfword of B.
- The two dual forms treat each operand as a pair of independent signed 16-bit values. They add both 16x16 products into the sum. The straight form pairs top with top and bottom with bottom. The exchanged form pairs each half of A with the opposite half of B.

Every product is sign-extended to 64 bits before it is added. The addition wraps modulo 2^64. The block has no status or flag output.

A request is accepted in any cycle where `inValid` is high. Its result is registered and appears one clock later, with `outValid` high for exactly that cycle. A new request can be accepted in every cycle. The caller supplies operands and collects results; there is no back-pressure.

Top module: `dual_half_mac`

## Requirements
- R1: With opCode 2'b00, the result is {accHi,accLo} plus the signed product of the full 32-bit opA and opB.
- R2: With opCode 2'b01, the result is {accHi,accLo} plus the product of two signed halfwords, sign-extended to 64 bits. The A halfword is opA[31:16] when selTopA is 1 and opA[15:0] when it is 0. selTopB picks the B halfword in the same way.
- R3: With opCode 2'b10, the result is {accHi,accLo} + opA[31:16]*opB[31:16] + opA[15:0]*opB[15:0]. All four halves are signed 16-bit values.
- R4: With opCode 2'b11, the result is {accHi,accLo} + opA[31:16]*opB[15:0] + opA[15:0]*opB[31:16]. All four halves are signed 16-bit values.
- R5: The accumulation wraps modulo 2^64 without saturation. For example, 0x7FFFFFFFFFFFFFFF + 1 gives 0x8000000000000000.
- R6: No 16x16 product is truncated before the sum is formed. In dual mode, with every half equal to 0x8000 and a zero accumulator, the result is 2^31 (resHi = 0, resLo = 0x80000000).
- R7: outValid is high in the cycle after inValid is sampled high, and low in the cycle after inValid is sampled low. The result is presented together with outValid.
- R8: A synchronous active-high rst clears outValid, resLo and resHi to zero on the next clock edge.
- R9: While inValid is low, resLo and resHi keep their previous values.
- R10: selTopA and selTopB have no effect on the result for opCodes 2'b00, 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request accepted this cycle |
| opCode | input | 2 | 00 full, 01 single, 10 dual, 11 dual exchanged |
| selTopA | input | 1 | Single mode: 1 uses the top half of opA |
| selTopB | input | 1 | Single mode: 1 uses the top half of opB |
| opA | input | 32 | First multiplicand |
| opB | input | 32 | Second multiplicand |
| accLo | input | 32 | Accumulator bits 31:0 |
| accHi | input | 32 | Accumulator bits 63:32 |
| outValid | output | 1 | Result valid this cycle |
| resLo | output | 32 | Result bits 31:0 |
| resHi | output | 32 | Result bits 63:32 |

## Verification
Two events can fall in the same cycle: presenting the result of request N and accepting request N+1. A back-to-back request with different operands would be the first to corrupt that earlier result.

The bench provokes this by issuing requests on every cycle with no gaps. The sweep covers all opcodes, select combinations, operand words and accumulator values. In each cycle the bench compares the result against a model computed in the bench from the previous cycle's inputs, then drives the next request.

After the stream ends, one idle cycle must show the last result with outValid high. The next idle cycle must show outValid low with the result unchanged.

// File: rtl/dual_half_mac_pkg.sv
`timescale 1ns/1ps
package dual_half_mac_pkg;

  localparam int LANES = 2;

  typedef enum logic [1:0] {
    OP_FULL   = 2'b00,
    OP_SINGLE = 2'b01,
    OP_DUAL   = 2'b10,
    OP_DUALX  = 2'b11
  } macOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             fullMode;
    logic [LANES-1:0] laneEn;
    logic [LANES-1:0] laneATop;
    logic [LANES-1:0] laneBTop;
  } macStrobe_t;

endpackage

// File: rtl/dual_half_mac_ctrl.sv
`timescale 1ns/1ps
module dual_half_mac_ctrl
  import dual_half_mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] opCode,
  input  logic       selTopA,
  input  logic       selTopB,
  output macStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe          = '0;
    strobe.load     = inValid;
    unique case (macOp_e'(opCode))
      OP_FULL: begin
        strobe.fullMode = 1'b1;
      end
      OP_SINGLE: begin
        strobe.laneEn      = 2'b01;
        strobe.laneATop[0] = selTopA;
        strobe.laneBTop[0] = selTopB;
      end
      OP_DUAL: begin
        // lane 0 pairs the top halves, lane 1 pairs the bottom halves
        strobe.laneEn   = 2'b11;
        strobe.laneATop = 2'b01;
        strobe.laneBTop = 2'b01;
      end
      OP_DUALX: begin
        // lane 0: top A with bottom B; lane 1: bottom A with top B
        strobe.laneEn   = 2'b11;
        strobe.laneATop = 2'b01;
        strobe.laneBTop = 2'b10;
      end
      default: strobe.laneEn = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/dual_half_mac_dp.sv
`timescale 1ns/1ps
module dual_half_mac_dp
  import dual_half_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  macStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accLo,
  input  logic [DATA_W-1:0] accHi,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi
);

  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;
  localparam int EXT_W  = ACC_W - DATA_W;

  logic [ACC_W-1:0] laneExt [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [HALF_W-1:0] halfA;
    logic signed [HALF_W-1:0] halfB;
    logic signed [DATA_W-1:0] laneProd;

    assign halfA    = strobe.laneATop[g] ? opA[DATA_W-1:HALF_W] : opA[HALF_W-1:0];
    assign halfB    = strobe.laneBTop[g] ? opB[DATA_W-1:HALF_W] : opB[HALF_W-1:0];
    assign laneProd = halfA * halfB;
    assign laneExt[g] = strobe.laneEn[g]
                      ? {{EXT_W{laneProd[DATA_W-1]}}, laneProd}
                      : '0;
  end

  logic [ACC_W-1:0] extA, extB, fullProd, laneSum, addend, nextAcc;

  assign extA     = {{EXT_W{opA[DATA_W-1]}}, opA};
  assign extB     = {{EXT_W{opB[DATA_W-1]}}, opB};
  assign fullProd = extA * extB;

  always_comb begin
    laneSum = '0;
    for (int i = 0; i < LANES; i++) laneSum = laneSum + laneExt[i];
  end

  assign addend  = strobe.fullMode ? fullProd : laneSum;
  assign nextAcc = {accHi, accLo} + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      resLo <= '0;
      resHi <= '0;
    end else if (strobe.load) begin
      resLo <= nextAcc[DATA_W-1:0];
      resHi <= nextAcc[ACC_W-1:DATA_W];
    end
  end

endmodule

// File: rtl/dual_half_mac.sv
`timescale 1ns/1ps
module dual_half_mac
  import dual_half_mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        opCode,
  input  logic              selTopA,
  input  logic              selTopB,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] accLo,
  input  logic [DATA_W-1:0] accHi,
  output logic              outValid,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi
);

  macStrobe_t strobe;

  dual_half_mac_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opCode   (opCode),
    .selTopA  (selTopA),
    .selTopB  (selTopB),
    .strobe   (strobe),
    .outValid (outValid)
  );

  dual_half_mac_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .accLo  (accLo),
    .accHi  (accHi),
    .resLo  (resLo),
    .resHi  (resHi)
  );

endmodule

// File: rtl/dual_half_mac_chk.sv
`timescale 1ns/1ps
module dual_half_mac_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [1:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] accLo,
  input logic [DATA_W-1:0] accHi,
  input logic              outValid,
  input logic [DATA_W-1:0] resLo,
  input logic [DATA_W-1:0] resHi
);

  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = 2 * DATA_W;

  // Independent model of the straight dual form
  logic signed [HALF_W-1:0] aT, aB, bT, bB;
  logic signed [ACC_W-1:0]  pTop, pBot;
  logic [ACC_W-1:0]         dualExpect;

  assign aT = opA[DATA_W-1:HALF_W];
  assign aB = opA[HALF_W-1:0];
  assign bT = opB[DATA_W-1:HALF_W];
  assign bB = opB[HALF_W-1:0];
  assign pTop = ACC_W'(aT) * ACC_W'(bT);
  assign pBot = ACC_W'(aB) * ACC_W'(bB);
  assign dualExpect = {accHi, accLo} + pTop + pBot;

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable({resHi, resLo}));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!outValid && resLo == '0 && resHi == '0));

  p_dual_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 2'b10) |=> ({resHi, resLo} == $past(dualExpect)));

endmodule

bind dual_half_mac dual_half_mac_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .accLo    (accLo),
  .accHi    (accHi),
  .outValid (outValid),
  .resLo    (resLo),
  .resHi    (resHi)
);

// File: tb/dual_half_mac_tb.sv
`timescale 1ns/1ps
module dual_half_mac_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [1:0]  opCode;
  logic        selTopA, selTopB;
  logic [31:0] opA, opB, accLo, accHi;
  logic        outValid;
  logic [31:0] resLo, resHi;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  always #2 clk = ~clk;

  dual_half_mac u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode),
    .selTopA(selTopA), .selTopB(selTopB), .opA(opA), .opB(opB),
    .accLo(accLo), .accHi(accHi), .outValid(outValid),
    .resLo(resLo), .resHi(resHi)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op, input bit sa,
      input bit sb, input logic [31:0] a, input logic [31:0] b,
      input logic [63:0] acc);
    shortint aT, aB, bT, bB, ha, hb;
    longint  p;
    aT = a[31:16]; aB = a[15:0]; bT = b[31:16]; bB = b[15:0];
    case (op)
      2'b00: p = longint'(int'(a)) * longint'(int'(b));
      2'b01: begin
        ha = sa ? aT : aB;
        hb = sb ? bT : bB;
        p  = longint'(ha) * longint'(hb);
      end
      2'b10: p = longint'(aT) * longint'(bT) + longint'(aB) * longint'(bB);
      default: p = longint'(aT) * longint'(bB) + longint'(aB) * longint'(bT);
    endcase
    return acc + p;
  endfunction

  task automatic drive(input logic [1:0] op, input bit sa, input bit sb,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] acc);
    inValid = 1'b1; opCode = op; selTopA = sa; selTopB = sb;
    opA = a; opB = b; {accHi, accLo} = acc;
  endtask

  logic [31:0] words [8];
  logic [63:0] accs  [4];
  logic [63:0] expRes;
  string       expTag;
  bit          pend;

  initial begin
    words[0] = 32'h0000_0000; words[1] = 32'h0000_0001;
    words[2] = 32'hFFFF_FFFF; words[3] = 32'h7FFF_8000;
    words[4] = 32'h8000_7FFF; words[5] = 32'h8000_8000;
    words[6] = 32'h1234_5678; words[7] = 32'hEDCB_A987;
    accs[0] = 64'h0;                  accs[1] = 64'h7FFF_FFFF_FFFF_FFFF;
    accs[2] = 64'h8000_0000_0000_0000; accs[3] = 64'h0123_4567_89AB_CDEF;

    rst = 1'b1; inValid = 1'b0; opCode = 2'b00; selTopA = 1'b0; selTopB = 1'b0;
    opA = '0; opB = '0; accLo = '0; accHi = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!outValid && resLo == 0 && resHi == 0, "R8 reset state",
          {resHi, resLo}, 64'h0);
    rst = 1'b0;

    // Back-to-back sweep: result N checked while request N+1 is driven
    pend = 0;
    for (int op = 0; op < 4; op++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            if (pend) begin
              check(outValid, "R7 outValid after request", {63'h0, outValid}, 64'h1);
              check({resHi, resLo} == expRes, expTag, {resHi, resLo}, expRes);
            end
            drive(2'(op), s[1], s[0], words[i], words[j], accs[(i + j) % 4]);
            expRes = model(2'(op), s[1], s[0], words[i], words[j], accs[(i + j) % 4]);
            case (op)
              0: expTag = (s != 0) ? "R10 selects ignored (full)" : "R1 full multiply";
              1: expTag = "R2 single halfword";
              2: expTag = (s != 0) ? "R10 selects ignored (dual)" : "R3 dual straight";
              default: expTag = (s != 0) ? "R10 selects ignored (dualx)" : "R4 dual exchanged";
            endcase
            pend = 1;
          end
        end
      end
    end

    // R5: wrap-around
    @(negedge clk);
    check({resHi, resLo} == expRes, expTag, {resHi, resLo}, expRes);
    drive(2'b00, 1'b0, 1'b0, 32'h1, 32'h1, 64'h7FFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    check({resHi, resLo} == 64'h8000_0000_0000_0000, "R5 modulo wrap",
          {resHi, resLo}, 64'h8000_0000_0000_0000);
    // R6: no product truncation
    drive(2'b10, 1'b0, 1'b0, 32'h8000_8000, 32'h8000_8000, 64'h0);
    @(negedge clk);
    check(resHi == 32'h0 && resLo == 32'h8000_0000, "R6 no truncation",
          {resHi, resLo}, 64'h0000_0000_8000_0000);
    // Last request before idle: exchanged form
    drive(2'b11, 1'b1, 1'b0, 32'h0003_FFFE, 32'h0005_0007, 64'd100);
    expRes = 64'd100 + 64'd21 + 64'hFFFF_FFFF_FFFF_FFF6;
    @(negedge clk);
    check({resHi, resLo} == expRes, "R4 exchanged directed", {resHi, resLo}, expRes);
    inValid = 1'b0;
    opA = 32'hDEAD_BEEF; opB = 32'h1357_9BDF; accLo = 32'h5555_5555;
    @(negedge clk);
    check(!outValid, "R7 outValid drops", {63'h0, outValid}, 64'h0);
    check({resHi, resLo} == expRes, "R9 hold while idle", {resHi, resLo}, expRes);
    @(negedge clk);
    check({resHi, resLo} == expRes, "R9 hold second idle", {resHi, resLo}, expRes);

    // R8: reset mid-stream
    drive(2'b00, 1'b0, 1'b0, 32'h7, 32'h9, 64'h1);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    check(!outValid && {resHi, resLo} == 64'h0, "R8 mid-run reset",
          {resHi, resLo}, 64'h0);
    rst = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule